// File: doc/BRIEF.md
# Sampling-Delay Calibration Sweeper

This block calibrates the sampling delay of a card-interface receiver. A start request makes it step a programmable delay line through every tap of the sweep. The sweep covers either 32 or 64 taps. At each tap it asks an external test agent to run one tuning transfer and waits for the result. Each tap's pass or fail goes into a bitmap. The block tracks the longest unbroken run of passing taps and reports the tap at the middle of that run as the delay to use. Placing the sample point there keeps it as far as possible from the failing edges on either side.

Software or a link manager starts a sweep at bring-up. It starts another whenever conditions call for a fresh calibration, for example after switching to another storage region. Every such request repeats the whole sweep. The short sweep finishes in about half the time of the long one, because each tap costs one tuning transfer. The long sweep resolves the window more finely.

The controller is a five-state machine:
- `ST_IDLE`: waits for start.
- `ST_TEST`: drives the tap and holds the test request until the agent answers.
- `ST_STEP`: a one-cycle gap while the next tap is applied.
- `ST_LATCH`: captures the results.
- `ST_DONE`: pulses done.

Its transitions are:
- IDLE→TEST on start.
- TEST→STEP on a result for any tap but the last.
- TEST→LATCH on the result for the last tap.
- STEP→TEST always.
- LATCH→DONE always.
- DONE→IDLE always.

Top module: `delay_tap_calibrator`

## Requirements
- R1: `step_sel_i` is sampled with `start_i`. A value of 0 selects a 32-tap sweep, which is the default. A value of 1 selects a 64-tap sweep. Exactly that many tuning transfers are issued per sweep.
- R2: Taps are visited in ascending order from 0. `test_req_o` stays high with `tap_o` held until a `test_done_i` pulse arrives. The tap then advances by one, and `test_req_o` drops for one cycle before the next request.
- R3: Bit i of `bitmap_o` is the `test_pass_i` value returned at tap i. In a 32-tap sweep, bits 63:32 read as zero.
- R4: `max_len_o` is the length of the longest contiguous run of set bitmap bits. The search does not wrap from the top tap to tap 0. For example, 0xffffffffffff003f gives 48, and 0x00000000ffffffc0 gives 26.
- R5: `final_tap_o` equals the run's start tap plus the run length divided by two and rounded down. The two examples above give 40 and 19.
- R6: When several runs share the maximum length, the run with the lowest start tap is chosen.
- R7: When no tap passes, `fail_o` is 1, `final_tap_o` is 0 and `max_len_o` is 0. Otherwise `fail_o` is 0.
- R8: `busy_o` rises the cycle after `start_i` is accepted. It stays high through a single-cycle `done_o` pulse and falls the cycle after it. A `start_i` pulse while `busy_o` is high is ignored.
- R9: The result outputs stay unchanged from `done_o` until the next accepted start. A new start repeats the full sweep from tap 0.
- R10: After reset, `busy_o`, `done_o`, `test_req_o` and `fail_o` are 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration sweep (accepted when idle) |
| step_sel_i | input | 1 | Sweep length: 0 = 32 taps, 1 = 64 taps |
| test_done_i | input | 1 | Single-cycle result strobe from the test agent |
| test_pass_i | input | 1 | Tuning transfer passed, valid with test_done_i |
| tap_o | output | 6 | Delay tap applied to the delay line |
| test_req_o | output | 1 | Request one tuning transfer at tap_o |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| fail_o | output | 1 | No passing tap was found |
| bitmap_o | output | 64 | Pass/fail per tap, bit 0 = tap 0 |
| max_len_o | output | 7 | Length of the widest passing run |
| final_tap_o | output | 6 | Centre tap of the widest passing run |

## Verification
After an accepted start, `test_req_o` and tap 0 appear one clock later. After each agent strobe, the request drops for one clock and reappears with the next tap. After the strobe for the final tap, the latch state takes one clock, and `done_o` rises in the clock after that.

The bench never counts cycles to find the results. It polls `done_o` on falling edges and compares every result output there against its own window search. It checks on the following falling edge that `busy_o` and `done_o` have dropped. It then re-reads the outputs several cycles later to confirm they hold.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_STEP,
        ST_LATCH,
        ST_DONE
    } cal_state_t;
endpackage

// File: rtl/tap_sweep_fsm.sv
module tap_sweep_fsm
    import tap_cal_pkg::*;
#(
    parameter int LONG_STEPS  = 64,
    parameter int SHORT_STEPS = 32,
    parameter int TAP_W       = $clog2(LONG_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             long_i,
    input  logic             test_done_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             test_req_o,
    output logic             clear_o,
    output logic             record_o,
    output logic             latch_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             long_q_o
);
    localparam logic [TAP_W-1:0] LAST_LONG  = TAP_W'(LONG_STEPS - 1);
    localparam logic [TAP_W-1:0] LAST_SHORT = TAP_W'(SHORT_STEPS - 1);

    cal_state_t state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic             long_q;
    logic             at_last;

    assign at_last = (tap_q == (long_q ? LAST_LONG : LAST_SHORT));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_TEST;
            ST_TEST:  if (test_done_i) state_d = at_last ? ST_LATCH : ST_STEP;
            ST_STEP:  state_d = ST_TEST;
            ST_LATCH: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                tap_q  <= '0;
                long_q <= long_i;
            end else if (state_q == ST_TEST && test_done_i && !at_last) begin
                tap_q <= tap_q + TAP_W'(1);
            end
        end
    end

    always_comb begin
        test_req_o = 1'b0;
        clear_o    = 1'b0;
        record_o   = 1'b0;
        latch_o    = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o  = 1'b0;
                clear_o = start_i;
            end
            ST_TEST: begin
                test_req_o = 1'b1;
                record_o   = test_done_i;
            end
            ST_STEP:  ;
            ST_LATCH: latch_o = 1'b1;
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assign tap_o    = tap_q;
    assign long_q_o = long_q;

    // R2: a request never drives a tap outside the selected sweep
    assert_req_tap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        test_req_o |-> (tap_q <= (long_q ? LAST_LONG : LAST_SHORT)));
    // R2: tap advances by exactly one after a non-final result
    assert_tap_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req_o && test_done_i && !at_last) |=> (tap_q == $past(tap_q) + TAP_W'(1)));
    // R2: request holds the tap until a result strobe
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req_o && !test_done_i) |=> (test_req_o && $stable(tap_q)));
    // R8: done is followed by idle
    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    // R8: busy only rises on an accepted start
    assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/pass_run_scanner.sv
module pass_run_scanner #(
    parameter int LONG_STEPS = 64,
    parameter int TAP_W      = $clog2(LONG_STEPS),
    parameter int LEN_W      = TAP_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  record_i,
    input  logic                  pass_i,
    input  logic [TAP_W-1:0]      tap_i,
    output logic [LONG_STEPS-1:0] bitmap_o,
    output logic [LEN_W-1:0]      best_len_o,
    output logic [TAP_W-1:0]      best_start_o
);
    logic [LEN_W-1:0] cur_len_q, best_len_q, grown_len;
    logic [TAP_W-1:0] cur_start_q, best_start_q, run_start;

    for (genvar g = 0; g < LONG_STEPS; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bitmap_o[g] <= 1'b0;
            else if (clear_i)
                bitmap_o[g] <= 1'b0;
            else if (record_i && tap_i == TAP_W'(g))
                bitmap_o[g] <= pass_i;
        end
    end

    assign grown_len = cur_len_q + LEN_W'(1);
    assign run_start = (cur_len_q == '0) ? tap_i : cur_start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_len_q    <= '0;
            cur_start_q  <= '0;
            best_len_q   <= '0;
            best_start_q <= '0;
        end else if (clear_i) begin
            cur_len_q    <= '0;
            cur_start_q  <= '0;
            best_len_q   <= '0;
            best_start_q <= '0;
        end else if (record_i) begin
            if (pass_i) begin
                cur_len_q   <= grown_len;
                cur_start_q <= run_start;
                if (grown_len > best_len_q) begin   // strict: earlier run wins ties (R6)
                    best_len_q   <= grown_len;
                    best_start_q <= run_start;
                end
            end else begin
                cur_len_q <= '0;
            end
        end
    end

    assign best_len_o   = best_len_q;
    assign best_start_o = best_start_q;

    // R4: the widest run never shrinks within a sweep
    assert_best_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (best_len_q >= $past(best_len_q)));
    // R6: a run of equal length found later does not move the start
    assert_tie_keeps_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && record_i && pass_i && grown_len <= best_len_q) |=> $stable(best_start_q));
endmodule

// File: rtl/delay_tap_calibrator.sv
module delay_tap_calibrator #(
    parameter int LONG_STEPS  = 64,
    parameter int SHORT_STEPS = 32,
    parameter int TAP_W       = $clog2(LONG_STEPS),
    parameter int LEN_W       = TAP_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  step_sel_i,
    input  logic                  test_done_i,
    input  logic                  test_pass_i,
    output logic [TAP_W-1:0]      tap_o,
    output logic                  test_req_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  fail_o,
    output logic [LONG_STEPS-1:0] bitmap_o,
    output logic [LEN_W-1:0]      max_len_o,
    output logic [TAP_W-1:0]      final_tap_o
);
    logic                  clear_w, record_w, latch_w, long_q_w;
    logic [LONG_STEPS-1:0] scan_map;
    logic [LEN_W-1:0]      scan_len, centre_sum;
    logic [TAP_W-1:0]      scan_start;

    tap_sweep_fsm #(
        .LONG_STEPS(LONG_STEPS), .SHORT_STEPS(SHORT_STEPS), .TAP_W(TAP_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_i(step_sel_i),
        .test_done_i(test_done_i), .tap_o(tap_o), .test_req_o(test_req_o),
        .clear_o(clear_w), .record_o(record_w), .latch_o(latch_w),
        .busy_o(busy_o), .done_o(done_o), .long_q_o(long_q_w)
    );

    pass_run_scanner #(
        .LONG_STEPS(LONG_STEPS), .TAP_W(TAP_W), .LEN_W(LEN_W)
    ) scan_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .record_i(record_w),
        .pass_i(test_pass_i), .tap_i(tap_o), .bitmap_o(scan_map),
        .best_len_o(scan_len), .best_start_o(scan_start)
    );

    assign centre_sum = LEN_W'(scan_start) + (scan_len >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitmap_o    <= '0;
            max_len_o   <= '0;
            final_tap_o <= '0;
            fail_o      <= 1'b0;
        end else if (latch_w) begin
            bitmap_o    <= scan_map;
            max_len_o   <= scan_len;
            final_tap_o <= centre_sum[TAP_W-1:0];
            fail_o      <= (scan_len == '0);
        end
    end

    // R3: short sweeps leave the upper half of the map clear
    assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !long_q_w) |-> (bitmap_o[LONG_STEPS-1:SHORT_STEPS] == '0));
    // R7: a failed sweep reports tap 0 and no window
    assert_fail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (final_tap_o == '0 && max_len_o == '0 && bitmap_o == '0));
    // R9: results hold while idle
    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(bitmap_o) && $stable(final_tap_o) && $stable(max_len_o)));
endmodule

// File: tb/delay_tap_calibrator_tb.sv
module delay_tap_calibrator_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, step_sel_i = 1'b0, test_done_i = 1'b0, test_pass_i = 1'b0;
    logic [5:0]  tap_o, final_tap_o;
    logic        test_req_o, busy_o, done_o, fail_o;
    logic [63:0] bitmap_o;
    logic [6:0]  max_len_o;

    int checks = 0, errors = 0;
    int xfer_cnt = 0, tap_bad = 0, exp_tap = 0;
    logic [63:0] model_pat = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    delay_tap_calibrator dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_sel_i(step_sel_i),
        .test_done_i(test_done_i), .test_pass_i(test_pass_i), .tap_o(tap_o),
        .test_req_o(test_req_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .bitmap_o(bitmap_o), .max_len_o(max_len_o), .final_tap_o(final_tap_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // window search: for each start, measure its run; strict > keeps the lowest start
    function automatic void best_window(input logic [63:0] pat, input int n,
                                        output int len, output int tap);
        int bs = 0;
        len = 0;
        for (int s = 0; s < n; s++) begin
            int l = 0;
            while (s + l < n && pat[s + l]) l++;
            if (l > len) begin len = l; bs = s; end
        end
        tap = bs + len / 2;
    endfunction

    // test agent: answers each request after a random delay
    initial begin
        forever begin
            @(negedge clk);
            if (test_req_o) begin
                if (int'(tap_o) != exp_tap) tap_bad++;
                repeat ($urandom_range(3)) begin
                    @(negedge clk);
                    if (!test_req_o || int'(tap_o) != exp_tap) tap_bad++;
                end
                test_done_i = 1'b1;
                test_pass_i = model_pat[tap_o];
                exp_tap++;
                xfer_cnt++;
                @(negedge clk);
                test_done_i = 1'b0;
                test_pass_i = 1'($urandom);
            end
        end
    end

    task automatic sweep(input logic [63:0] pat, input bit long_mode, input bit poke);
        int n, elen, etap;
        logic [63:0] emap;
        logic [63:0] snap_map;
        logic [6:0]  snap_len;
        logic [5:0]  snap_tap;
        n = long_mode ? 64 : 32;
        emap = long_mode ? pat : {32'h0, pat[31:0]};
        best_window(emap, n, elen, etap);
        model_pat = pat;
        xfer_cnt = 0; tap_bad = 0; exp_tap = 0;
        @(negedge clk);
        step_sel_i = long_mode; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; step_sel_i = 1'($urandom);
        check(busy_o === 1'b1, "R8", "busy after start", 64'(busy_o), 64'd1);
        if (poke) begin
            repeat (7) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        check(busy_o === 1'b1, "R8", "busy during done", 64'(busy_o), 64'd1);
        check(xfer_cnt == n, "R1", "transfer count", 64'(xfer_cnt), 64'(n));
        check(tap_bad == 0, "R2", "tap order/hold errors", 64'(tap_bad), 64'd0);
        check(bitmap_o === emap, "R3", "bitmap", bitmap_o, emap);
        check(int'(max_len_o) == elen, "R4", "max length", 64'(max_len_o), 64'(elen));
        check(int'(final_tap_o) == etap, "R5", "final tap", 64'(final_tap_o), 64'(etap));
        check(fail_o === (elen == 0), "R7", "fail flag", 64'(fail_o), 64'(elen == 0));
        snap_map = bitmap_o; snap_len = max_len_o; snap_tap = final_tap_o;
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R8", "done/busy after pulse",
              64'({done_o, busy_o}), 64'd0);
        repeat (4) @(negedge clk);
        check(bitmap_o === snap_map && max_len_o === snap_len && final_tap_o === snap_tap,
              "R9", "results held", 64'(final_tap_o), 64'(snap_tap));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(busy_o === 0 && done_o === 0 && test_req_o === 0 && fail_o === 0,
              "R10", "control outputs in reset", 64'({busy_o, done_o, test_req_o, fail_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bitmap_o === '0 && max_len_o === '0 && final_tap_o === '0,
              "R10", "results after reset", bitmap_o, 64'd0);
        // directed corner cases
        sweep(64'hffffffffffff003f, 1'b1, 1'b0);  // R4 R5 long example: 48 / 40
        sweep(64'h00000000ffffffc0, 1'b0, 1'b0);  // R4 R5 short example: 26 / 19
        sweep(64'h0000000000000f0f, 1'b0, 1'b0);  // R6 tie: tap 2
        sweep(64'h0, 1'b1, 1'b0);                 // R7 no pass
        sweep(64'hffffffffffffffff, 1'b1, 1'b0);  // full long window: 64 / 32
        sweep(64'hffffffffffffffff, 1'b0, 1'b0);  // R3 upper half cleared, 32 / 16
        sweep(64'hf00000000000000f, 1'b1, 1'b0);  // R4 no wraparound: 4 / 2
        sweep(64'h00ff0000ff00ff00, 1'b1, 1'b1);  // R8 start while busy ignored
        // constrained random, R9 re-tune repeats full sweep each time
        for (int k = 0; k < 12; k++) begin
            logic [63:0] p;
            int a, b;
            a = $urandom_range(63);
            b = $urandom_range(63);
            p = {$urandom, $urandom};
            if (k % 2 == 0)
                for (int i = 0; i < 64; i++) p[i] = (i >= a && i <= b) || (p[i] && p[(i + 1) % 64]);
            sweep(p, 1'($urandom), 1'b0);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule